// File: doc/BRIEF.md
# Display register read engine

This block reads configuration and status registers from a small display controller over a four-wire serial link: a chip select, a serial clock, a data-out line, a data-in line, and a separate data/command select line. A requester presents an opcode and a byte count from 1 to 4, then pulses a start strobe. The engine first checks the opcode and the count. If the request is valid, it selects the command path on the data/command line and shifts the opcode out. It then clocks in the response and returns the bytes together with a completion pulse and an error flag.

Two opcodes, the identification read (0x04) and the status read (0x09), are answered by controllers that insert one dummy clock before the data. For these two, the engine clocks one byte more than was requested and shifts the whole response left by one bit, so that the requester still receives clean bytes. The serial clock rate is fixed when the block is built. It comes from the system clock frequency, the highest frequency the bus allows, and a fixed ceiling for read traffic.

Top module: `dbi_reg_reader`

## Requirements
- R1: While reset is high and in the cycle after it is released: `spi_cs_n`=1, `spi_sclk`=0, `spi_dcx`=1, `spi_mosi`=0, `busy`=0, `done`=0, `err`=0 and `rdata`=0.
- R2: Only these opcodes may be read: 0x04, 0x06, 0x07, 0x08, 0x09, 0x0A, 0x0B, 0x0C, 0x0D, 0x0E, 0x0F, 0x2E, 0x3E, 0x45, 0x52, 0x54, 0x56, 0x5F, 0xA1, 0xA8. Any other opcode is reported in the cycle after the request with `done`=1 and `err`=1, and `spi_cs_n` never goes low.
- R3: For opcodes other than 0x04 and 0x09, a count of 0 or a count above 4 is reported as an error in the cycle after the request, with no bus activity.
- R4: For opcodes 0x04 and 0x09, only the counts 3 and 4 are accepted. Every other count is reported as an error in the cycle after the request, with no bus activity.
- R5: During an accepted read, `spi_cs_n` and `spi_dcx` are both low for the whole frame. `spi_sclk` idles low and rises at the centre of each bit (SPI mode 0). The opcode goes out on `spi_mosi` MSB first, and `spi_mosi` is 0 while the response is received.
- R6: An accepted read gives exactly 8*(1+n) rising `spi_sclk` edges in a single chip-select window. Here n is the count, or the count plus 1 for opcodes 0x04 and 0x09.
- R7: For ordinary opcodes, received byte i (0 = first) appears on `rdata[8i+7:8i]` without change. Byte lanes at or above the count are 0, and `err`=0.
- R8: For opcodes 0x04 and 0x09, output byte i is received byte i shifted left by one bit, with bit 7 of received byte i+1 placed in its LSB. Lanes at or above the count are 0.
- R9: `spi_sclk` toggles every H system clocks, where H = ceil(CLK_HZ / (2*min(2 MHz, BUS_MAX_HZ/2))). H is never less than 2.
- R10: A start strobe that arrives while `busy`=1 is ignored. It does not change the frame that is in progress, and it produces no second completion.
- R11: `done` is high for exactly one cycle per request. `err` and `rdata` keep their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | One-cycle request strobe |
| req_opcode | input | 8 | Register opcode to read |
| req_len | input | LEN_W | Requested byte count |
| busy | output | 1 | A read is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request was rejected |
| rdata | output | 8*LEN_MAX | Returned bytes, first byte in the low lane |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the controller |
| spi_miso | input | 1 | Serial data from the controller |
| spi_dcx | output | 1 | Data/command select, low for command |

## Verification
If the bit counter or the frame length held a wrong value, the number of serial clock pulses in the chip-select window would be wrong. The slave model in the bench counts these pulses, so the error appears at the end of that same frame. The bench also models a controller with a leading dummy clock. Because of that, an off-by-one in the realignment shift, or a wrong choice of opcodes that need it, shows up in the returned bytes at the completion pulse. A fault in the request check shows up one cycle after the strobe: either an accepted frame where an error was expected, or an error where a frame was expected. Every opcode is swept against every count to catch these.

// File: rtl/dbi_rd_pkg.sv
package dbi_rd_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rd_state_e;

  // opcodes the controller answers with data
  function automatic logic op_readable(input logic [7:0] op);
    case (op)
      8'h04, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E,
      8'h0F, 8'h2E, 8'h3E, 8'h45, 8'h52, 8'h54, 8'h56, 8'h5F, 8'hA1, 8'hA8:
        return 1'b1;
      default:
        return 1'b0;
    endcase
  endfunction

  // opcodes whose answer starts with one dummy clock
  function automatic logic op_dummy_lead(input logic [7:0] op);
    return (op == 8'h04) || (op == 8'h09);
  endfunction

endpackage

// File: rtl/dbi_rd_divider.sv
module dbi_rd_divider #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(HALF - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/dbi_rd_serdes.sv
module dbi_rd_serdes #(
  parameter int RAW_W = 40,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [7:0]       cmd,
  input  logic [CNT_W-1:0] last_bit,
  input  logic             tick,
  input  logic             miso,
  output logic             active,
  output logic             sclk,
  output logic             cs_n,
  output logic             dcx,
  output logic             mosi,
  output logic             fin,
  output logic [RAW_W-1:0] raw
);
  logic [7:0]       txsh;
  logic [CNT_W-1:0] bitno;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      sclk   <= 1'b0;
      cs_n   <= 1'b1;
      dcx    <= 1'b1;
      mosi   <= 1'b0;
      fin    <= 1'b0;
      raw    <= '0;
      txsh   <= '0;
      bitno  <= '0;
    end else begin
      fin <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        cs_n   <= 1'b0;
        dcx    <= 1'b0;
        sclk   <= 1'b0;
        mosi   <= cmd[7];
        txsh   <= {cmd[6:0], 1'b0};
        bitno  <= '0;
        raw    <= '0;
      end else if (active && tick) begin
        if (!sclk) begin
          // rising edge: sample only once the opcode is out
          sclk <= 1'b1;
          if (bitno >= CNT_W'(8)) raw <= {raw[RAW_W-2:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitno == last_bit) begin
            active <= 1'b0;
            cs_n   <= 1'b1;
            dcx    <= 1'b1;
            mosi   <= 1'b0;
            fin    <= 1'b1;
          end else begin
            bitno <= bitno + 1'b1;
            mosi  <= txsh[7];
            txsh  <= {txsh[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/dbi_rd_align.sv
module dbi_rd_align #(
  parameter int OUT_BYTES = 4,
  parameter int RAW_W     = 40,
  parameter int NB_W      = 3
) (
  input  logic [RAW_W-1:0]       raw,
  input  logic [NB_W-1:0]        rx_bytes,
  input  logic                   skip_bit,
  input  logic [NB_W-1:0]        keep_bytes,
  output logic [8*OUT_BYTES-1:0] data
);
  localparam int OUT_W = 8 * OUT_BYTES;
  localparam int SH_W  = $clog2(RAW_W + 1);

  logic [SH_W-1:0]  amt;
  logic [OUT_W-1:0] top_part;

  // left-justify the received stream, dropping the dummy bit if present
  assign amt      = SH_W'(RAW_W) - SH_W'({rx_bytes, 3'b000}) + SH_W'(skip_bit);
  assign top_part = OUT_W'((raw << amt) >> (RAW_W - OUT_W));

  for (genvar i = 0; i < OUT_BYTES; i++) begin : g_lane
    assign data[8*i +: 8] = (NB_W'(i) < keep_bytes) ? top_part[OUT_W-1-8*i -: 8] : 8'h00;
  end
endmodule

// File: rtl/dbi_reg_reader.sv
module dbi_reg_reader
  import dbi_rd_pkg::*;
#(
  parameter int CLK_HZ      = 250_000_000,
  parameter int BUS_MAX_HZ  = 20_000_000,
  parameter int READ_CAP_HZ = 2_000_000,
  parameter int LEN_MAX     = 4,
  parameter int LEN_W       = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_start,
  input  logic [7:0]           req_opcode,
  input  logic [LEN_W-1:0]     req_len,
  output logic                 busy,
  output logic                 done,
  output logic                 err,
  output logic [8*LEN_MAX-1:0] rdata,
  output logic                 spi_cs_n,
  output logic                 spi_sclk,
  output logic                 spi_mosi,
  input  logic                 spi_miso,
  output logic                 spi_dcx
);
  localparam int RD_HZ    = (BUS_MAX_HZ / 2 < READ_CAP_HZ) ? BUS_MAX_HZ / 2 : READ_CAP_HZ;
  localparam int HALF_RAW = (CLK_HZ + 2 * RD_HZ - 1) / (2 * RD_HZ);
  localparam int HALF     = (HALF_RAW < 2) ? 2 : HALF_RAW;
  localparam int RX_MAX   = LEN_MAX + 1;
  localparam int RAW_W    = 8 * RX_MAX;
  localparam int BITS_MAX = 8 + RAW_W;
  localparam int CNT_W    = $clog2(BITS_MAX);
  localparam int NB_W     = $clog2(RX_MAX + 1);
  localparam int OUT_W    = 8 * LEN_MAX;

  rd_state_e        state;
  logic             lead_d, len_ok_d, legal_d, go;
  logic [NB_W-1:0]  rxn_d, rxn_q, keep_q;
  logic             lead_q;
  logic [CNT_W-1:0] last_d, last_q;
  logic             tick, active, fin;
  logic [RAW_W-1:0] raw;
  logic [OUT_W-1:0] aligned;

  always_comb begin
    lead_d   = op_dummy_lead(req_opcode);
    len_ok_d = lead_d ? (req_len == LEN_W'(3) || req_len == LEN_W'(4))
                      : (req_len != '0 && req_len <= LEN_W'(LEN_MAX));
    legal_d  = op_readable(req_opcode) && len_ok_d;
    rxn_d    = NB_W'(req_len) + NB_W'(lead_d);
    last_d   = CNT_W'({rxn_d, 3'b111});
    go       = req_start && (state == ST_IDLE) && legal_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      busy   <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      rdata  <= '0;
      rxn_q  <= '0;
      keep_q <= '0;
      lead_q <= 1'b0;
      last_q <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_start) begin
            if (legal_d) begin
              state  <= ST_RUN;
              busy   <= 1'b1;
              rxn_q  <= rxn_d;
              keep_q <= NB_W'(req_len);
              lead_q <= lead_d;
              last_q <= last_d;
            end else begin
              done  <= 1'b1;
              err   <= 1'b1;
              rdata <= '0;
            end
          end
        end
        ST_RUN: begin
          if (fin) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
            err   <= 1'b0;
            rdata <= aligned;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  dbi_rd_divider #(.HALF(HALF)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (active),
    .tick (tick)
  );

  dbi_rd_serdes #(.RAW_W(RAW_W), .CNT_W(CNT_W)) u_ser (
    .clk      (clk),
    .rst      (rst),
    .start    (go),
    .cmd      (req_opcode),
    .last_bit (last_q),
    .tick     (tick),
    .miso     (spi_miso),
    .active   (active),
    .sclk     (spi_sclk),
    .cs_n     (spi_cs_n),
    .dcx      (spi_dcx),
    .mosi     (spi_mosi),
    .fin      (fin),
    .raw      (raw)
  );

  dbi_rd_align #(.OUT_BYTES(LEN_MAX), .RAW_W(RAW_W), .NB_W(NB_W)) u_align (
    .raw        (raw),
    .rx_bytes   (rxn_q),
    .skip_bit   (lead_q),
    .keep_bytes (keep_q),
    .data       (aligned)
  );
endmodule

// File: rtl/dbi_rd_checker.sv
module dbi_rd_checker (
  input logic clk,
  input logic rst,
  input logic req_start,
  input logic busy,
  input logic done,
  input logic err,
  input logic spi_cs_n,
  input logic spi_sclk,
  input logic spi_dcx
);
  // R5: serial clock rests low outside a frame
  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);

  // R5: command select held low for the whole frame
  p_dc_low_r5: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> !spi_dcx);

  // R11: completion is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: a rejected request never touched the bus
  p_err_no_bus_r2: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (spi_cs_n && $past(spi_cs_n)));

  // R10: a frame only starts from a strobe
  p_start_cause_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_start));

  // R9: the serial clock never toggles on two cycles in a row
  p_sclk_slow_r9: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk != $past(spi_sclk)) |=> $stable(spi_sclk));
endmodule

bind dbi_reg_reader dbi_rd_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_start (req_start),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .spi_cs_n  (spi_cs_n),
  .spi_sclk  (spi_sclk),
  .spi_dcx   (spi_dcx)
);

// File: tb/test_dbi_reg_reader.sv
`timescale 1ns/1ps
module test_dbi_reg_reader;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        req_start = 1'b0;
  logic [7:0]  req_opcode = 8'h00;
  logic [2:0]  req_len = 3'd0;
  logic        busy, done, err;
  logic [31:0] rdata;
  logic        cs_n, sclk, mosi, dcx;
  logic        miso = 1'b0;

  dbi_reg_reader #(.CLK_HZ(8_000_000), .BUS_MAX_HZ(2_000_000)) i_dbi_reg_reader (
    .clk(clk), .rst(rst), .req_start(req_start), .req_opcode(req_opcode),
    .req_len(req_len), .busy(busy), .done(done), .err(err), .rdata(rdata),
    .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso),
    .spi_dcx(dcx)
  );

  // second build: bus fast enough that the 2 MHz read ceiling applies
  logic        c_start = 1'b0;
  logic        c_busy, c_done, c_err, c_cs_n, c_sclk, c_mosi, c_dcx;
  logic [31:0] c_rdata;
  dbi_reg_reader #(.CLK_HZ(8_000_000), .BUS_MAX_HZ(40_000_000)) i_dbi_reg_reader_cap (
    .clk(clk), .rst(rst), .req_start(c_start), .req_opcode(8'h0A),
    .req_len(3'd1), .busy(c_busy), .done(c_done), .err(c_err), .rdata(c_rdata),
    .spi_cs_n(c_cs_n), .spi_sclk(c_sclk), .spi_mosi(c_mosi), .spi_miso(1'b0),
    .spi_dcx(c_dcx)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] rb(input logic [7:0] op, input int len, input int j);
    return 8'((int'(op) * 7 + j * 37 + len * 11 + 90) % 256);
  endfunction

  logic [7:0] rd_ops [20] = '{8'h04, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C,
                              8'h0D, 8'h0E, 8'h0F, 8'h2E, 8'h3E, 8'h45, 8'h52, 8'h54,
                              8'h56, 8'h5F, 8'hA1, 8'hA8};

  function automatic bit in_list(input logic [7:0] op);
    for (int i = 0; i < 20; i++) if (rd_ops[i] == op) return 1'b1;
    return 1'b0;
  endfunction

  // controller model
  logic [7:0] cur_op = 8'h00;
  int         cur_len = 0;
  int         rises = 0, falls = 0, cs_falls = 0, dones = 0;
  logic [7:0] cmd_seen = 8'h00;
  bit         dc_bad = 0, mosi_bad = 0;
  time        last_rise = 0, prev_rise = 0, c_last = 0, c_prev = 0;

  always @(posedge sclk) begin
    rises++;
    prev_rise = last_rise;
    last_rise = $time;
    if (rises <= 8) cmd_seen = {cmd_seen[6:0], mosi};
    else if (mosi) mosi_bad = 1;
  end

  always @(negedge sclk) begin
    int k;
    logic [7:0] b;
    falls++;
    if (falls >= 8) begin
      k = falls - 8;
      b = rb(cur_op, cur_len, k / 8);
      miso = b[7 - (k % 8)];
    end
  end

  always @(negedge cs_n) cs_falls++;
  always @(posedge clk) begin
    if (!cs_n && dcx) dc_bad = 1;
    if (done) dones++;
  end
  always @(posedge c_sclk) begin
    c_prev = c_last;
    c_last = $time;
  end

  task automatic clear_model(input logic [7:0] op, input int len);
    rises = 0; falls = 0; cs_falls = 0; dones = 0;
    cmd_seen = 8'h00; dc_bad = 0; mosi_bad = 0;
    cur_op = op; cur_len = len;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_req(input logic [7:0] op, input int len);
    bit lead, legal;
    int n, rx;
    logic [31:0] exp, held;
    logic [7:0] b0, b1;
    @(negedge clk);
    clear_model(op, len);
    req_opcode = op;
    req_len = 3'(len);
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    wait_done(n);
    lead  = (op == 8'h04) || (op == 8'h09);
    legal = in_list(op) && (lead ? (len == 3 || len == 4) : (len >= 1 && len <= 4));
    rx    = lead ? len + 1 : len;
    chk(done == 1'b1, "R11 completion seen", 64'(done), 64'd1);
    chk(err == !legal, lead ? "R4 error flag" : (in_list(op) ? "R3 error flag" : "R2 error flag"),
        64'(err), 64'(!legal));
    if (!legal) begin
      chk(n == 0 && cs_falls == 0, "R2 R3 R4 immediate reject without bus", 64'(cs_falls), 64'd0);
      chk(rdata == 32'h0, "R2 data cleared on reject", 64'(rdata), 64'd0);
    end else begin
      chk(cs_falls == 1, "R6 single select window", 64'(cs_falls), 64'd1);
      chk(rises == 8 * (1 + rx), "R6 clock count", 64'(rises), 64'(8 * (1 + rx)));
      chk(cmd_seen == op, "R5 opcode on mosi", 64'(cmd_seen), 64'(op));
      chk(!dc_bad && !mosi_bad, "R5 dcx low and mosi idle", 64'({dc_bad, mosi_bad}), 64'd0);
      exp = 32'h0;
      for (int i = 0; i < 4; i++) begin
        if (i < len) begin
          b0 = rb(op, len, i);
          b1 = rb(op, len, i + 1);
          exp[8*i +: 8] = lead ? {b0[6:0], b1[7]} : b0;
        end
      end
      chk(rdata == exp, lead ? "R8 realigned data" : "R7 plain data", 64'(rdata), 64'(exp));
    end
    held = rdata;
    @(negedge clk);
    chk(!done && rdata == held && err == !legal, "R11 pulse and hold", 64'({done, rdata}), 64'(held));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (5) @(negedge clk);
    chk(cs_n && !sclk && dcx && !mosi && !busy && !done && !err && rdata == 0,
        "R1 reset state", 64'({cs_n, sclk, dcx, mosi, busy, done, err}), 64'b1010000);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n && !sclk && dcx && !busy && !done && rdata == 0,
        "R1 after release", 64'({cs_n, sclk, dcx, busy, done}), 64'b10100);

    // R9: serial clock period, bus-limited build (H=4) and ceiling build (H=2)
    do_req(8'h0A, 1);
    chk(last_rise - prev_rise == 32, "R9 period bus-limited", 64'(last_rise - prev_rise), 64'd32);
    @(negedge clk);
    c_start = 1'b1;
    @(negedge clk);
    c_start = 1'b0;
    n = 0;
    while (!c_done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(c_done && !c_err, "R9 ceiling build completes", 64'({c_done, c_err}), 64'b10);
    chk(c_last - c_prev == 16, "R9 period at ceiling", 64'(c_last - c_prev), 64'd16);

    // R10: strobe while busy is ignored
    @(negedge clk);
    clear_model(8'h0B, 2);
    req_opcode = 8'h0B;
    req_len = 3'd2;
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    repeat (20) @(negedge clk);
    req_opcode = 8'h45;
    req_len = 3'd1;
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    req_opcode = 8'h0B;
    wait_done(n);
    repeat (30) @(negedge clk);
    chk(cmd_seen == 8'h0B && rises == 24, "R10 frame unchanged", 64'({cmd_seen, 8'(rises)}), 64'h0B18);
    chk(dones == 1 && cs_falls == 1, "R10 single completion", 64'(dones), 64'd1);
    chk(rdata == {16'h0, rb(8'h0B, 2, 1), rb(8'h0B, 2, 0)}, "R10 R7 data of first request",
        64'(rdata), 64'({16'h0, rb(8'h0B, 2, 1), rb(8'h0B, 2, 0)}));

    // R2 R3 R4 R5 R6 R7 R8: every opcode against every count
    for (int op = 0; op < 256; op++) begin
      for (int len = 0; len < 8; len++) begin
        do_req(8'(op), len);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule